// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the condition and mode flags of an 8-bit accumulator CPU core. Six flags have storage: negative, overflow, decimal, interrupt-disable, zero and carry. Two further positions of the status byte have no storage and are filled in when the byte is formed. Position 5 is always one. Position 4 marks who caused a stack push: it is one for a software push and zero for a hardware interrupt push.

The block has three ways to change the flags. The ALU writes them through per-flag enables. A small command port sets or clears single flags. A parallel load restores all six stored flags from a byte pulled off the stack. It drives two bytes. One is the status as read inside the core. The other is the byte to be written to the stack, formatted for the cause of the push given on its inputs. When a hardware interrupt pushes status, the interrupt-disable flag is raised at the same clock edge. The pushed byte still shows the old value.

Top module: `cpu_status_reg`

## Requirements
- R1: While `rst` is high at a rising edge, the stored flags become I=1 and all others 0. `status_o` then reads 0x34.
- R2: Bit 5 of `status_o` and of `push_o` is always 1.
- R3: Status byte layout, bit 7 down to bit 0: N, V, constant one, break marker, D, I, Z, C. When `load_en` is high, the next edge loads N, V, D, I, Z, C from `load_byte` bits 7, 6, 3, 2, 1, 0. Bits 5 and 4 of `load_byte` are ignored, so loading 0x00 reads back as 0x30.
- R4: Bit 4 of `status_o` is always 1. Bit 4 of `push_o` is 1 when `push_hw` is 0 (software push) and 0 when `push_hw` is 1 (hardware interrupt push). All other bits of `push_o` equal those of `status_o`.
- R5: `cmd` codes: 0 none, 1 clear C, 2 set C, 3 clear I, 4 set I, 5 clear D, 6 set D, 7 clear V. A command takes effect at the next rising edge. Code 0 changes nothing.
- R6: `alu_we` and `alu_val` use bit 3 for N, bit 2 for V, bit 1 for Z and bit 0 for C. A flag whose enable is high takes its value at the next edge. A flag whose enable is low keeps its value.
- R7: When `push_en` and `push_hw` are both high, I becomes 1 at the next edge. During that cycle `push_o` shows the previous I. A software push (`push_hw` low) changes no flag.
- R8: Priority, highest first: load, then the hardware-push I set, then `cmd`, then the ALU update. A command wins over an ALU write to the same flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Restore flags from `load_byte` |
| load_byte | input | 8 | Status byte pulled from the stack |
| cmd | input | 3 | Single-flag set/clear command |
| alu_we | input | 4 | ALU per-flag write enables {N,V,Z,C} |
| alu_val | input | 4 | ALU flag values {N,V,Z,C} |
| push_en | input | 1 | Status is being pushed this cycle |
| push_hw | input | 1 | Cause of push: 1 hardware interrupt, 0 software |
| status_o | output | 8 | Status byte for internal reads |
| push_o | output | 8 | Status byte formatted for the stack |

## Verification
Every flag change passes through one register stage. Load, command, ALU and interrupt effects therefore appear on `status_o` exactly one rising edge after the stimulus. The bench drives inputs on the falling edge and samples `status_o` one nanosecond after the next rising edge. `push_o` is combinational from the stored flags and `push_hw`. It is sampled in the same cycle the push is requested, before the edge that raises I, so the old I value can be seen in the pushed byte. Priority cases apply conflicting sources in one cycle and read the single winner on the following edge.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;

    localparam int BYTE_W  = 8;
    localparam int POS_N   = 7;
    localparam int POS_V   = 6;
    localparam int POS_ONE = 5;
    localparam int POS_BRK = 4;
    localparam int POS_D   = 3;
    localparam int POS_I   = 2;
    localparam int POS_Z   = 1;
    localparam int POS_C   = 0;

    localparam int ALU_W = 4;
    localparam int ALU_N = 3;
    localparam int ALU_V = 2;
    localparam int ALU_Z = 1;
    localparam int ALU_C = 0;

    localparam int CMD_W = 3;

    typedef struct packed {
        logic n;
        logic v;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{n: 1'b0, v: 1'b0, d: 1'b0, i: 1'b1, z: 1'b0, c: 1'b0};

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE  = 3'd0,
        CMD_CLR_C = 3'd1,
        CMD_SET_C = 3'd2,
        CMD_CLR_I = 3'd3,
        CMD_SET_I = 3'd4,
        CMD_CLR_D = 3'd5,
        CMD_SET_D = 3'd6,
        CMD_CLR_V = 3'd7
    } flag_cmd_e;

    // Positions 5 and 4 of the byte carry no storage and are dropped here.
    function automatic flags_t unpack_byte(input logic [BYTE_W-1:0] b);
        flags_t f;
        f.n = b[POS_N];
        f.v = b[POS_V];
        f.d = b[POS_D];
        f.i = b[POS_I];
        f.z = b[POS_Z];
        f.c = b[POS_C];
        return f;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_byte(input flags_t f, input logic brk);
        logic [BYTE_W-1:0] b;
        b          = '0;
        b[POS_N]   = f.n;
        b[POS_V]   = f.v;
        b[POS_ONE] = 1'b1;
        b[POS_BRK] = brk;
        b[POS_D]   = f.d;
        b[POS_I]   = f.i;
        b[POS_Z]   = f.z;
        b[POS_C]   = f.c;
        return b;
    endfunction

    function automatic logic [ALU_W-1:0] alu_view(input flags_t f);
        logic [ALU_W-1:0] a;
        a[ALU_N] = f.n;
        a[ALU_V] = f.v;
        a[ALU_Z] = f.z;
        a[ALU_C] = f.c;
        return a;
    endfunction

endpackage

// File: rtl/cpu_status_alu_merge.sv
module cpu_status_alu_merge
    import cpu_status_pkg::*;
#(
    parameter int N_BITS = ALU_W
) (
    input  logic [N_BITS-1:0] cur_bits,
    input  logic [N_BITS-1:0] wr_en,
    input  logic [N_BITS-1:0] wr_val,
    output logic [N_BITS-1:0] merged
);

    for (genvar g = 0; g < N_BITS; g++) begin : g_bit
        assign merged[g] = wr_en[g] ? wr_val[g] : cur_bits[g];
    end

endmodule

// File: rtl/cpu_status_next.sv
module cpu_status_next
    import cpu_status_pkg::*;
(
    input  flags_t              cur,
    input  logic [ALU_W-1:0]    alu_bits,
    input  logic [CMD_W-1:0]    cmd,
    input  logic                irq_push,
    input  logic                load_en,
    input  logic [BYTE_W-1:0]   load_byte,
    output flags_t              nxt
);

    flag_cmd_e cmd_e;
    assign cmd_e = flag_cmd_e'(cmd);

    always_comb begin
        // Lowest priority: ALU results.
        nxt   = cur;
        nxt.n = alu_bits[ALU_N];
        nxt.v = alu_bits[ALU_V];
        nxt.z = alu_bits[ALU_Z];
        nxt.c = alu_bits[ALU_C];

        // Single-flag commands override the ALU.
        case (cmd_e)
            CMD_CLR_C: nxt.c = 1'b0;
            CMD_SET_C: nxt.c = 1'b1;
            CMD_CLR_I: nxt.i = 1'b0;
            CMD_SET_I: nxt.i = 1'b1;
            CMD_CLR_D: nxt.d = 1'b0;
            CMD_SET_D: nxt.d = 1'b1;
            CMD_CLR_V: nxt.v = 1'b0;
            default:   ;
        endcase

        // Hardware interrupt push masks further interrupts.
        if (irq_push) begin
            nxt.i = 1'b1;
        end

        // A pull from the stack replaces everything.
        if (load_en) begin
            nxt = unpack_byte(load_byte);
        end
    end

endmodule

// File: rtl/cpu_status_store.sv
module cpu_status_store
    import cpu_status_pkg::*;
#(
    parameter flags_t RST_VAL = FLAGS_RESET
) (
    input  logic   clk,
    input  logic   rst,
    input  flags_t d,
    output flags_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
    import cpu_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [7:0]        load_byte,
    input  logic [2:0]        cmd,
    input  logic [3:0]        alu_we,
    input  logic [3:0]        alu_val,
    input  logic              push_en,
    input  logic              push_hw,
    output logic [7:0]        status_o,
    output logic [7:0]        push_o
);

    flags_t              flags_q;
    flags_t              flags_d;
    logic [ALU_W-1:0]    alu_merged;
    logic                irq_push;

    assign irq_push = push_en & push_hw;

    cpu_status_alu_merge #(
        .N_BITS (ALU_W)
    ) u_alu_merge (
        .cur_bits (alu_view(flags_q)),
        .wr_en    (alu_we),
        .wr_val   (alu_val),
        .merged   (alu_merged)
    );

    cpu_status_next u_next (
        .cur       (flags_q),
        .alu_bits  (alu_merged),
        .cmd       (cmd),
        .irq_push  (irq_push),
        .load_en   (load_en),
        .load_byte (load_byte),
        .nxt       (flags_d)
    );

    cpu_status_store #(
        .RST_VAL (FLAGS_RESET)
    ) u_store (
        .clk (clk),
        .rst (rst),
        .d   (flags_d),
        .q   (flags_q)
    );

    // Internal read always shows the break position as one.
    assign status_o = pack_byte(flags_q, 1'b1);
    // Stack copy: break position marks a software-caused push.
    assign push_o   = pack_byte(flags_q, ~push_hw);

endmodule

// File: rtl/cpu_status_chk.sv
module cpu_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       load_en,
    input logic [7:0] load_byte,
    input logic [2:0] cmd,
    input logic [3:0] alu_we,
    input logic       push_en,
    input logic       push_hw,
    input logic [7:0] status_o,
    input logic [7:0] push_o
);

    assert_one_bit_R2: assert property (@(posedge clk) disable iff (rst)
        status_o[5] && push_o[5]);

    assert_read_brk_R4: assert property (@(posedge clk) disable iff (rst)
        status_o[4]);

    assert_push_brk_R4: assert property (@(posedge clk) disable iff (rst)
        push_o[4] == !push_hw);

    assert_push_match_R4: assert property (@(posedge clk) disable iff (rst)
        (push_o[7:5] == status_o[7:5]) && (push_o[3:0] == status_o[3:0]));

    assert_load_R3: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (status_o[7:6] == $past(load_byte[7:6]))
                 && (status_o[3:0] == $past(load_byte[3:0])));

    assert_irq_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (push_en && push_hw && !load_en) |=> status_o[2]);

    assert_set_c_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd2 && !load_en) |=> status_o[0]);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!load_en && cmd == 3'd0 && alu_we == 4'd0 && !(push_en && push_hw))
            |=> $stable(status_o));

endmodule

bind cpu_status_reg cpu_status_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_byte (load_byte),
    .cmd       (cmd),
    .alu_we    (alu_we),
    .push_en   (push_en),
    .push_hw   (push_hw),
    .status_o  (status_o),
    .push_o    (push_o)
);

// File: tb/cpu_status_reg_tb_top.sv
`timescale 1ns/1ps
module cpu_status_reg_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       load_en;
    logic [7:0] load_byte;
    logic [2:0] cmd;
    logic [3:0] alu_we;
    logic [3:0] alu_val;
    logic       push_en;
    logic       push_hw;
    logic [7:0] status_o;
    logic [7:0] push_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cpu_status_reg dut_i (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_byte (load_byte),
        .cmd       (cmd),
        .alu_we    (alu_we),
        .alu_val   (alu_val),
        .push_en   (push_en),
        .push_hw   (push_hw),
        .status_o  (status_o),
        .push_o    (push_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        load_en = 1'b0; load_byte = 8'h00; cmd = 3'd0;
        alu_we = 4'h0; alu_val = 4'h0; push_en = 1'b0; push_hw = 1'b0;
    endtask

    // Drive one cycle of stimulus at the falling edge, let one rising edge pass.
    task automatic step(input logic le, input logic [7:0] lb, input logic [2:0] c,
                        input logic [3:0] we, input logic [3:0] v,
                        input logic pe, input logic ph);
        @(negedge clk);
        load_en = le; load_byte = lb; cmd = c;
        alu_we = we; alu_val = v; push_en = pe; push_hw = ph;
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic do_load(input logic [7:0] b);
        step(1'b1, b, 3'd0, 4'h0, 4'h0, 1'b0, 1'b0);
    endtask

    task automatic do_cmd(input logic [2:0] c, input logic [7:0] exp, input string req);
        step(1'b0, 8'h00, c, 4'h0, 4'h0, 1'b0, 1'b0);
        chk(req, status_o, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        idle();
        @(posedge clk); #1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset read", status_o, 8'h34);
        push_hw = 1'b0; #1;
        chk("R4 reset sw push", push_o, 8'h34);
        push_hw = 1'b1; #1;
        chk("R4 reset hw push", push_o, 8'h24);
        idle();
    endtask

    task automatic t_load();
        do_load(8'h00); chk("R3 load 00", status_o, 8'h30);
        do_load(8'hFF); chk("R3 load FF", status_o, 8'hFF);
        do_load(8'hCF); chk("R3 load CF ignores bits 5:4", status_o, 8'hFF);
        do_load(8'hA5); chk("R3 load A5", status_o, 8'hB5);
        do_load(8'h30); chk("R3 load 30", status_o, 8'h30);
        chk("R2 bit5 in push", {7'h0, push_o[5]}, 8'h01);
    endtask

    task automatic t_cmd();
        do_load(8'h00);
        do_cmd(3'd2, 8'h31, "R5 set C");
        do_cmd(3'd4, 8'h35, "R5 set I");
        do_cmd(3'd6, 8'h3D, "R5 set D");
        do_cmd(3'd1, 8'h3C, "R5 clear C");
        do_cmd(3'd3, 8'h38, "R5 clear I");
        do_cmd(3'd5, 8'h30, "R5 clear D");
        do_load(8'h40); chk("R3 load 40", status_o, 8'h70);
        do_cmd(3'd0, 8'h70, "R5 none holds");
        do_cmd(3'd7, 8'h30, "R5 clear V");
    endtask

    task automatic t_alu();
        do_load(8'h00);
        step(1'b0, 8'h00, 3'd0, 4'b1010, 4'b1111, 1'b0, 1'b0);
        chk("R6 write N,Z", status_o, 8'hB2);
        step(1'b0, 8'h00, 3'd0, 4'b1011, 4'b0101, 1'b0, 1'b0);
        chk("R6 write N,Z,C V held", status_o, 8'h31);
        step(1'b0, 8'h00, 3'd0, 4'b1111, 4'b1110, 1'b0, 1'b0);
        chk("R6 write N,V,Z,C", status_o, 8'hF2);
        step(1'b0, 8'h00, 3'd0, 4'b0000, 4'b0001, 1'b0, 1'b0);
        chk("R6 no enables holds", status_o, 8'hF2);
    endtask

    task automatic t_push();
        do_load(8'hC3);
        chk("R3 load C3", status_o, 8'hF3);
        @(negedge clk);
        push_en = 1'b1; push_hw = 1'b0; #1;
        chk("R4 sw push byte", push_o, 8'hF3);
        @(posedge clk); #1; idle();
        chk("R7 sw push leaves flags", status_o, 8'hF3);
        @(negedge clk);
        push_en = 1'b1; push_hw = 1'b1; #1;
        chk("R7 hw push byte old I", push_o, 8'hE3);
        @(posedge clk); #1; idle();
        chk("R7 hw push sets I", status_o, 8'hF7);
    endtask

    task automatic t_prio();
        do_load(8'hFF);
        step(1'b1, 8'h00, 3'd2, 4'hF, 4'hF, 1'b1, 1'b1);
        chk("R8 load wins all", status_o, 8'h30);
        step(1'b0, 8'h00, 3'd1, 4'b0001, 4'b0001, 1'b0, 1'b0);
        chk("R8 cmd clear C beats ALU", status_o, 8'h30);
        step(1'b0, 8'h00, 3'd2, 4'b0001, 4'b0000, 1'b0, 1'b0);
        chk("R8 cmd set C beats ALU", status_o, 8'h31);
        step(1'b0, 8'h00, 3'd3, 4'h0, 4'h0, 1'b1, 1'b1);
        chk("R8 hw push beats clear I", status_o, 8'h35);
        do_load(8'h40);
        step(1'b0, 8'h00, 3'd7, 4'b0100, 4'b0100, 1'b0, 1'b0);
        chk("R8 cmd clear V beats ALU", status_o, 8'h30);
    endtask

    initial begin
        rst = 1'b1;
        idle();
        repeat (3) @(posedge clk);
        t_reset();
        t_load();
        t_cmd();
        t_alu();
        t_push();
        t_prio();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule